// File: doc/BRIEF.md
# Pipelined Multiply-Add Array

This block computes `a*x + y` on unsigned K-bit operands and returns a 2K-bit result. It is a multiplier array built from rows of carry-save adders. Each row forms one partial product with a bank of AND gates, one gate for each bit of `a`, all gated by a single bit of `x`. The row then folds that partial product into a running sum/carry pair. The first row would normally start from zero. Here it starts from the addend `y`, so the addition costs no extra row. After the last row, a ripple carry-propagate adder resolves the sum/carry pair into binary.

A register bank follows every carry-save row, and another follows the carry-propagate adder. Each row stage moves the multiplicand and the bits of `x` not yet used forward with the partial sums, shifting `x` by one place per stage. The array therefore accepts one operation per cycle. Each result appears a fixed K+1 cycles after its operation is accepted, and results leave in issue order.

Both data ports use a valid/ready handshake. An operation transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. When a result is waiting and `out_ready` is low, the whole pipeline freezes. `in_ready` drops in that cycle, and the waiting result holds its value until it is taken.

Top module: `mac_array_pipe`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Every result equals `a*x + y` for the K-bit unsigned operands of its accepted operation, exactly, in 2K bits.
- R3: While `out_ready` stays high, a result appears on `out_valid` exactly K+1 clock cycles after the edge that accepted its operation.
- R4: While `out_ready` stays high, `in_ready` stays high, so a burst of N back-to-back operations yields N results on N consecutive cycles.
- R5: Results leave in the order their operations were accepted, and no result appears without an accepted operation.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_result` keeps its value on the next cycle.
- R7: `in_ready` equals `!out_valid || out_ready`. An operation offered while `in_ready` is 0 is not taken: it yields exactly one result, once it is accepted later.
- R8: The all-ones case `a = x = y = 2^K-1` gives `2^K*(2^K-1)` with no overflow.
- R9: If `a` or `x` is 0, the result equals `y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | K | Multiplicand |
| in_x | input | K | Multiplier |
| in_y | input | K | Addend |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 2K | `a*x + y` |

## Verification
The risky overlap is a stall that hits while operations keep arriving. In that cycle, a held result at the output must meet a refused input transfer, and every stage must freeze together. The bench provokes this by toggling `out_ready` pseudo-randomly while offering a fresh operation every cycle. A scoreboard checks that each queued expectation is matched once, in order, and that each held result keeps its value. In stretches with no stalls, the bench also checks the exact K+1 cycle latency and that results in a burst come out on consecutive cycles.

// File: rtl/mac_array_pkg.sv
package mac_array_pkg;
  parameter int unsigned DEF_K = 8;

  // bitwise full-adder vector: carry output not yet shifted
  function automatic logic [2*DEF_K-1:0] maj3(input logic [2*DEF_K-1:0] p,
                                              input logic [2*DEF_K-1:0] q,
                                              input logic [2*DEF_K-1:0] r);
    return (p & q) | (p & r) | (q & r);
  endfunction
endpackage

// File: rtl/mac_pp_gen.sv
module mac_pp_gen #(
  parameter int unsigned K   = 8,
  parameter int unsigned ROW = 0,
  localparam int unsigned W  = 2 * K
) (
  input  logic [K-1:0] a,
  input  logic         xbit,
  output logic [W-1:0] pp
);
  logic [K-1:0] gated;

  // one AND gate per multiplicand bit
  for (genvar i = 0; i < K; i++) begin : g_and
    assign gated[i] = a[i] & xbit;
  end

  assign pp = {{K{1'b0}}, gated} << ROW;
endmodule

// File: rtl/mac_csa_stage.sv
module mac_csa_stage #(
  parameter int unsigned K   = 8,
  parameter int unsigned ROW = 0,
  localparam int unsigned W  = 2 * K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_v,
  input  logic [K-1:0] in_a,
  input  logic [K-1:0] in_x,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_c,
  output logic         out_v,
  output logic [K-1:0] out_a,
  output logic [K-1:0] out_x,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_c
);
  logic [W-1:0] pp;
  logic [W-1:0] sum_n;
  logic [W-1:0] maj_n;

  mac_pp_gen #(.K(K), .ROW(ROW)) pp_i (
    .a    (in_a),
    .xbit (in_x[0]),
    .pp   (pp)
  );

  // carry-save row: three inputs folded into sum and carry
  always_comb begin
    sum_n = in_s ^ in_c ^ pp;
    maj_n = (in_s & in_c) | (in_s & pp) | (in_c & pp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_a <= '0;
      out_x <= '0;
      out_s <= '0;
      out_c <= '0;
    end else if (adv) begin
      out_v <= in_v;
      out_a <= in_a;
      out_x <= in_x >> 1;
      out_s <= sum_n;
      out_c <= {maj_n[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mac_cpa_stage.sv
module mac_cpa_stage #(
  parameter int unsigned K  = 8,
  localparam int unsigned W = 2 * K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_v,
  input  logic [W-1:0] in_s,
  input  logic [W-1:0] in_c,
  output logic         out_v,
  output logic [W-1:0] out_r
);
  logic [W:0]   cy;
  logic [W-1:0] bits;

  assign cy[0] = 1'b0;

  // ripple chain of full adders
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign bits[i]  = in_s[i] ^ in_c[i] ^ cy[i];
    assign cy[i+1]  = (in_s[i] & in_c[i]) | (cy[i] & (in_s[i] ^ in_c[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_r <= '0;
    end else if (adv) begin
      out_v <= in_v;
      out_r <= bits;
    end
  end
endmodule

// File: rtl/mac_array_pipe.sv
module mac_array_pipe #(
  parameter int unsigned K  = mac_array_pkg::DEF_K,
  localparam int unsigned W = 2 * K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_a,
  input  logic [K-1:0] in_x,
  input  logic [K-1:0] in_y,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result
);
  logic         adv;
  logic         v_p [K+1];
  logic [K-1:0] a_p [K+1];
  logic [K-1:0] x_p [K+1];
  logic [W-1:0] s_p [K+1];
  logic [W-1:0] c_p [K+1];

  // whole pipeline moves unless a result is waiting and refused
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // the row that would start from zero starts from the addend
  assign v_p[0] = in_valid;
  assign a_p[0] = in_a;
  assign x_p[0] = in_x;
  assign s_p[0] = {{K{1'b0}}, in_y};
  assign c_p[0] = '0;

  for (genvar r = 0; r < K; r++) begin : g_row
    mac_csa_stage #(.K(K), .ROW(r)) row_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .in_v  (v_p[r]),
      .in_a  (a_p[r]),
      .in_x  (x_p[r]),
      .in_s  (s_p[r]),
      .in_c  (c_p[r]),
      .out_v (v_p[r+1]),
      .out_a (a_p[r+1]),
      .out_x (x_p[r+1]),
      .out_s (s_p[r+1]),
      .out_c (c_p[r+1])
    );
  end

  mac_cpa_stage #(.K(K)) cpa_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .in_v  (v_p[K]),
    .in_s  (s_p[K]),
    .in_c  (c_p[K]),
    .out_v (out_valid),
    .out_r (out_result)
  );
endmodule

// File: rtl/mac_array_pipe_chk.sv
module mac_array_pipe_chk #(
  parameter int unsigned K  = 8,
  localparam int unsigned W = 2 * K,
  localparam int unsigned OW = $clog2(K + 3) + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [K-1:0] in_a,
  input logic [K-1:0] in_x,
  input logic [K-1:0] in_y,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result
);
  logic [W-1:0]  ref_d [K+1];
  logic [K:0]    ref_v;
  logic [OW-1:0] occ;

  // arithmetic reference moved along with the accepted stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_v <= '0;
      for (int i = 0; i <= K; i++) ref_d[i] <= '0;
    end else if (in_ready) begin
      ref_v    <= {ref_v[K-1:0], in_valid};
      ref_d[0] <= W'(in_a) * W'(in_x) + W'(in_y);
      for (int i = 1; i <= K; i++) ref_d[i] <= ref_d[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OW'(in_valid && in_ready) - OW'(out_valid && out_ready);
  end

  // R2
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result == ref_d[K]);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == ref_v[K]);

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(K + 1));

  // R5
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != '0);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
endmodule

bind mac_array_pipe mac_array_pipe_chk #(.K(K)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_x       (in_x),
  .in_y       (in_y),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/mac_array_pipe_tb_top.sv
`timescale 1ns/1ps
module mac_array_pipe_tb_top;
  localparam int K = 8;
  localparam int W = 2 * K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_a = '0;
  logic [K-1:0] in_x = '0;
  logic [K-1:0] in_y = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 0;
  bit done = 0;

  logic [W-1:0] exp_q [$];
  int           iss_q [$];
  bit           lat_q [$];
  string        tag_q [$];

  bit           burst_on = 0;
  int           burst_n = 0;
  int           burst_first = -1;
  int           burst_last = -1;
  bit           prev_stall = 0;
  logic [W-1:0] prev_res = '0;

  always #4 clk = ~clk;

  mac_array_pipe #(.K(K)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_a       (in_a),
    .in_x       (in_x),
    .in_y       (in_y),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [K-1:0] a, input logic [K-1:0] x,
                      input logic [K-1:0] y, input bit lat, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a; in_x = x; in_y = y;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(W'(a) * W'(x) + W'(y));
    iss_q.push_back(cyc);
    lat_q.push_back(lat);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R7 ready rule
      check(in_ready == (!out_valid || out_ready), "R7 ready",
            W'(in_ready), W'(!out_valid || out_ready));
      // R6 held result
      if (prev_stall)
        check(out_valid && out_result == prev_res, "R6 hold", out_result, prev_res);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result", out_result, '0);
        end else begin
          logic [W-1:0] e;
          int    t;
          bit    l;
          string g;
          e = exp_q.pop_front(); t = iss_q.pop_front();
          l = lat_q.pop_front(); g = tag_q.pop_front();
          check(out_result == e, {g, " R5 order"}, out_result, e);
          if (l) check(cyc - t == K + 1, "R3 latency", W'(cyc - t), W'(K + 1));
          if (burst_on) begin
            if (burst_first < 0) burst_first = cyc;
            burst_last = cyc;
            burst_n++;
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res = out_result;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready", W'(in_ready), W'(1));

    // corners
    send('0, '0, '0, 1, "R2 zero");
    send('1, '1, '1, 1, "R8 all ones");
    send('0, 8'hA5, 8'h3C, 1, "R9 a zero");
    send(8'h77, '0, 8'hFF, 1, "R9 x zero");
    send(8'h01, 8'hC3, 8'h00, 1, "R2 unit");
    for (int i = 0; i < K; i++)
      send(K'(1) << i, K'(1) << (K - 1 - i), K'(i * 17), 1, "R2 walking");
    idle();
    repeat (K + 4) @(negedge clk);

    // R4 burst with no stall
    burst_on = 1;
    for (int i = 0; i < 40; i++)
      send(K'($urandom), K'($urandom), K'($urandom), 1, "R4 burst");
    idle();
    repeat (K + 4) @(negedge clk);
    burst_on = 0;
    check(burst_n == 40, "R4 burst count", W'(burst_n), W'(40));
    check(burst_last - burst_first == 39, "R4 consecutive",
          W'(burst_last - burst_first), W'(39));

    // R6 R7 stalls under continuous offers
    stall_en = 1;
    for (int i = 0; i < 200; i++)
      send(K'($urandom), K'($urandom), K'($urandom), 0, "R2 stall");
    idle();
    stall_en = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5 drained", W'(out_valid), '0);
    finish_run();
  end
endmodule